// File: doc/BRIEF.md
# Sequential Multi-Digit Integer Multiplier

This block multiplies two long integers, each held as an array of 16-bit digits with digit 0 the least significant. The multiplicand `u` has `m` digits and the multiplier `v` has `n` digits. Either count may be the larger. The product is written into a third array of `m + n` digits. The block performs one 16x16 multiply-accumulate step per clock cycle. Each row of partial products is folded into the result array as it is formed, so no table of partial products is stored.

A mode input selects unsigned or two's-complement operation. In signed mode, the block first forms the unsigned product. It then runs up to two subtract-with-borrow passes over the upper part of the result to turn that value into the signed product. The arrays sit outside the block. The `u` and `v` arrays are reached through read ports. The result array is reached through one read port and one write port. All reads return data in the same cycle as the address.

Top module: `mwmul_top`

## Requirements
- R1: In unsigned mode, result digits 0 to m+n-1 hold the product of u and v, where digit k carries weight 2^(16k). This holds for every m from 1 to MAX_M and every n from 1 to MAX_N, chosen independently.
- R2: `done` is high for exactly one cycle. With start accepted on edge 0, `done` is first high after edge W, where W = m + n(m+1), plus n when signed mode has u negative, plus m when signed mode has v negative.
- R3: The result does not depend on what the result array held before start, because the low m digits are zeroed before any accumulation.
- R4: The 32-bit step accumulator never exceeds 2^32-1. Operands made entirely of 0xFFFF digits therefore give the exact product.
- R5: In signed mode, the operands are two's-complement numbers whose sign is bit 15 of their top digit. Result digits 0 to m+n-1 hold the two's-complement product.
- R6: In signed mode with both operands negative, the result is the positive product. The 2^(16(m+n)) cross term is left uncorrected.
- R7: In unsigned mode, no correction pass runs, even when the top digits have bit 15 set. Both the value and the latency follow the unsigned case.
- R8: A start pulse that arrives while an operation is running has no effect on that operation's result or timing.
- R9: The block writes no result index at or above m+n, and it writes nothing while idle.
- R10: The borrow is 0 at the first digit of each correction pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| m_cnt | input | $clog2(MAX_M+1) | Digit count of u (1..MAX_M) |
| n_cnt | input | $clog2(MAX_N+1) | Digit count of v (1..MAX_N) |
| u_addr | output | $clog2(MAX_M) | Read index into u |
| u_data | input | 16 | Digit of u at u_addr |
| v_addr | output | $clog2(MAX_N) | Read index into v |
| v_data | input | 16 | Digit of v at v_addr |
| w_raddr | output | $clog2(MAX_M+MAX_N) | Read index into result array |
| w_rdata | input | 16 | Result digit at w_raddr |
| w_we | output | 1 | Result write enable |
| w_waddr | output | $clog2(MAX_M+MAX_N) | Result write index |
| w_wdata | output | 16 | Result write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- `done` never lasts more than one cycle.
- No write happens while idle or at an index at or above m+n.
- Correction states are entered only in signed mode.
- Each correction pass starts with a clear borrow.
- The latched digit counts stay fixed while busy.
- The accumulator never carries out of 32 bits.

The product values need the bench's scenarios to show them, in both modes and for each combination of operand signs. So do the exact latency per sign case and the immunity to prior result contents and to a start pulse that arrives mid-run.

// File: rtl/mwmul_pkg.sv
package mwmul_pkg;
    localparam int DIG_W = 16;
    localparam int ACC_W = 2 * DIG_W;

    typedef logic [DIG_W-1:0] digit_t;
    typedef logic [ACC_W-1:0] acc_t;

    typedef enum logic [2:0] {
        S_IDLE, S_CLR, S_MUL, S_CRY, S_CU, S_CV, S_DONE
    } state_e;

    typedef enum logic [1:0] {
        WS_ZERO, WS_MAC, WS_CARRY, WS_SUB
    } wsel_e;

    typedef struct packed {
        digit_t hi;
        digit_t lo;
    } split_t;

    function automatic logic [ACC_W:0] mac_sum(digit_t a, digit_t b, digit_t w, digit_t k);
        return {1'b0, acc_t'(a) * acc_t'(b)} + (ACC_W+1)'(w) + (ACC_W+1)'(k);
    endfunction
endpackage

// File: rtl/mwmul_mac.sv
module mwmul_mac
    import mwmul_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   clr,
    input  digit_t a,
    input  digit_t b,
    input  digit_t w,
    output digit_t lo,
    output digit_t carry
);
    logic [ACC_W:0] sum;
    split_t         parts;

    always_comb begin
        sum   = mac_sum(a, b, w, carry);
        parts = split_t'(sum[ACC_W-1:0]);
        lo    = parts.lo;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) carry <= '0;
        else if (en)    carry <= parts.hi;
    end

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        en |-> (sum[ACC_W] == 1'b0));
endmodule

// File: rtl/mwmul_sub.sv
module mwmul_sub
    import mwmul_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   clr,
    input  digit_t a,
    input  digit_t b,
    output digit_t lo,
    output logic   borrow
);
    acc_t diff;

    always_comb begin
        diff = acc_t'(a) - acc_t'(b) - acc_t'(borrow);
        lo   = diff[DIG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) borrow <= 1'b0;
        else if (en)    borrow <= diff[ACC_W-1];
    end
endmodule

// File: rtl/mwmul_ctrl.sv
module mwmul_ctrl
    import mwmul_pkg::*;
#(
    parameter  int MAX_M = 6,
    parameter  int MAX_N = 5,
    localparam int MW  = $clog2(MAX_M + 1),
    localparam int NW  = $clog2(MAX_N + 1),
    localparam int UAW = $clog2(MAX_M),
    localparam int VAW = $clog2(MAX_N),
    localparam int WAW = $clog2(MAX_M + MAX_N),
    localparam int IW  = $clog2(MAX_M + MAX_N + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           signed_mode,
    input  logic [MW-1:0]  m_cnt,
    input  logic [NW-1:0]  n_cnt,
    input  logic           u_top,
    input  logic           v_top,
    output state_e         st_o,
    output wsel_e          wsel,
    output logic [UAW-1:0] u_addr,
    output logic [VAW-1:0] v_addr,
    output logic [WAW-1:0] w_raddr,
    output logic [WAW-1:0] w_waddr,
    output logic           w_we,
    output logic           mac_en,
    output logic           mac_clr,
    output logic           sub_en,
    output logic           sub_clr,
    output logic           sub_use_u,
    output logic           done
);
    state_e         st;
    logic [IW-1:0]  i_q, j_q, mm, nn;
    logic [MW-1:0]  m_q;
    logic [NW-1:0]  n_q;
    logic           sgn_q, uneg_q, vneg_q;
    logic           i_last, j_last;

    always_comb begin
        mm     = IW'(m_q);
        nn     = IW'(n_q);
        i_last = (i_q == mm - 1'b1);
        j_last = (j_q == nn - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE; i_q <= '0; j_q <= '0; m_q <= '0; n_q <= '0;
            sgn_q <= 1'b0; uneg_q <= 1'b0; vneg_q <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    m_q <= m_cnt; n_q <= n_cnt; sgn_q <= signed_mode;
                    uneg_q <= 1'b0; vneg_q <= 1'b0;
                    i_q <= '0; j_q <= '0; st <= S_CLR;
                end
                S_CLR: begin
                    i_q <= i_last ? '0 : i_q + 1'b1;
                    if (i_last) st <= S_MUL;
                end
                S_MUL: begin
                    if (i_last) uneg_q <= u_top;
                    if (j_last) vneg_q <= v_top;
                    i_q <= i_last ? '0 : i_q + 1'b1;
                    if (i_last) st <= S_CRY;
                end
                S_CRY: begin
                    i_q <= '0;
                    if (!j_last) begin
                        j_q <= j_q + 1'b1; st <= S_MUL;
                    end else begin
                        j_q <= '0;
                        if (sgn_q && uneg_q)      st <= S_CU;
                        else if (sgn_q && vneg_q) st <= S_CV;
                        else                      st <= S_DONE;
                    end
                end
                S_CU: begin
                    j_q <= j_last ? '0 : j_q + 1'b1;
                    if (j_last) st <= vneg_q ? S_CV : S_DONE;
                end
                S_CV: begin
                    i_q <= i_last ? '0 : i_q + 1'b1;
                    if (i_last) st <= S_DONE;
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        st_o = st; wsel = WS_ZERO; w_we = 1'b0; done = 1'b0;
        u_addr = UAW'(i_q); v_addr = VAW'(j_q);
        w_raddr = WAW'(i_q + j_q); w_waddr = WAW'(i_q + j_q);
        mac_en = 1'b0; mac_clr = 1'b0; sub_en = 1'b0; sub_use_u = 1'b0;
        sub_clr = !(st == S_CU || st == S_CV);
        case (st)
            S_IDLE: mac_clr = 1'b1;
            S_CLR: begin w_we = 1'b1; w_waddr = WAW'(i_q); end
            S_MUL: begin w_we = 1'b1; wsel = WS_MAC; mac_en = 1'b1; end
            S_CRY: begin
                w_we = 1'b1; wsel = WS_CARRY; mac_clr = 1'b1;
                w_waddr = WAW'(j_q + mm);
            end
            S_CU: begin
                w_we = 1'b1; wsel = WS_SUB; sub_en = 1'b1; sub_clr = j_last;
                w_raddr = WAW'(j_q + mm); w_waddr = WAW'(j_q + mm);
            end
            S_CV: begin
                w_we = 1'b1; wsel = WS_SUB; sub_en = 1'b1; sub_use_u = 1'b1;
                w_raddr = WAW'(i_q + nn); w_waddr = WAW'(i_q + nn);
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> !w_we);
    // R9
    write_bound_chk: assert property (@(posedge clk) disable iff (rst)
        w_we |-> (IW'(w_waddr) < mm + nn));
    // R7
    corr_signed_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_CU || st == S_CV) |-> sgn_q);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE) |=> ($stable(m_q) && $stable(n_q)));
endmodule

// File: rtl/mwmul_top.sv
module mwmul_top
    import mwmul_pkg::*;
#(
    parameter  int MAX_M = 6,
    parameter  int MAX_N = 5,
    localparam int MW  = $clog2(MAX_M + 1),
    localparam int NW  = $clog2(MAX_N + 1),
    localparam int UAW = $clog2(MAX_M),
    localparam int VAW = $clog2(MAX_N),
    localparam int WAW = $clog2(MAX_M + MAX_N)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           signed_mode,
    input  logic [MW-1:0]  m_cnt,
    input  logic [NW-1:0]  n_cnt,
    output logic [UAW-1:0] u_addr,
    input  logic [15:0]    u_data,
    output logic [VAW-1:0] v_addr,
    input  logic [15:0]    v_data,
    output logic [WAW-1:0] w_raddr,
    input  logic [15:0]    w_rdata,
    output logic           w_we,
    output logic [WAW-1:0] w_waddr,
    output logic [15:0]    w_wdata,
    output logic           done
);
    state_e st;
    wsel_e  wsel;
    logic   mac_en, mac_clr, sub_en, sub_clr, sub_use_u, borrow;
    digit_t mac_lo, carry, sub_lo, sub_b;

    mwmul_ctrl #(.MAX_M(MAX_M), .MAX_N(MAX_N)) ctrl_i (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .m_cnt(m_cnt), .n_cnt(n_cnt),
        .u_top(u_data[DIG_W-1]), .v_top(v_data[DIG_W-1]),
        .st_o(st), .wsel(wsel), .u_addr(u_addr), .v_addr(v_addr),
        .w_raddr(w_raddr), .w_waddr(w_waddr), .w_we(w_we),
        .mac_en(mac_en), .mac_clr(mac_clr), .sub_en(sub_en),
        .sub_clr(sub_clr), .sub_use_u(sub_use_u), .done(done)
    );

    mwmul_mac mac_i (
        .clk(clk), .rst(rst), .en(mac_en), .clr(mac_clr),
        .a(u_data), .b(v_data), .w(w_rdata), .lo(mac_lo), .carry(carry)
    );

    assign sub_b = sub_use_u ? u_data : v_data;

    mwmul_sub sub_i (
        .clk(clk), .rst(rst), .en(sub_en), .clr(sub_clr),
        .a(w_rdata), .b(sub_b), .lo(sub_lo), .borrow(borrow)
    );

    always_comb begin
        case (wsel)
            WS_MAC:   w_wdata = mac_lo;
            WS_CARRY: w_wdata = carry;
            WS_SUB:   w_wdata = sub_lo;
            default:  w_wdata = '0;
        endcase
    end

    // R10
    borrow_init_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == S_CU || st == S_CV) && $past(st) != st) |-> !borrow);
endmodule

// File: tb/mwmul_tb.sv
module mwmul_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MM = 6;
    localparam int NN = 5;
    localparam int WD = MM + NN;
    localparam int PB = 16 * WD + 16;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, signed_mode = 1'b0;
    logic [2:0] m_cnt = 3'd1, n_cnt = 3'd1;
    logic [2:0] u_addr, v_addr;
    logic [3:0] w_raddr, w_waddr;
    logic [15:0] u_data, v_data, w_rdata, w_wdata;
    logic w_we, done;

    logic [15:0] u_mem [MM];
    logic [15:0] v_mem [NN];
    logic [15:0] w_mem [WD];
    logic        fill_req = 1'b0;
    logic [15:0] fill_val = 16'h0;

    int errors = 0, checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign u_data  = u_mem[u_addr];
    assign v_data  = v_mem[v_addr];
    assign w_rdata = w_mem[w_raddr];

    always @(posedge clk) begin
        if (fill_req) begin
            for (int k = 0; k < WD; k++) w_mem[k] <= fill_val ^ 16'(k * 16'h1357);
        end else if (w_we) begin
            w_mem[w_waddr] <= w_wdata;
        end
    end

    mwmul_top #(.MAX_M(MM), .MAX_N(NN)) dut_i (
        .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
        .m_cnt(m_cnt), .n_cnt(n_cnt), .u_addr(u_addr), .u_data(u_data),
        .v_addr(v_addr), .v_data(v_data), .w_raddr(w_raddr), .w_rdata(w_rdata),
        .w_we(w_we), .w_waddr(w_waddr), .w_wdata(w_wdata), .done(done)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [PB-1:0] ext_val(input int cnt, input bit sgn, input bit is_u);
        logic [PB-1:0] r;
        logic top;
        top = is_u ? u_mem[cnt-1][15] : v_mem[cnt-1][15];
        for (int k = 0; k < PB; k++) begin
            if (k < 16 * cnt) r[k] = is_u ? u_mem[k/16][k%16] : v_mem[k/16][k%16];
            else              r[k] = sgn & top;
        end
        return r;
    endfunction

    task automatic run_op(input int m, input int n, input bit sgn, input bit inject, input string tag);
        logic [PB-1:0] p;
        logic [15:0] fv, got, want;
        int lat, cnt, bad_at;
        bit uneg, vneg, ok_res, ok_fill, saw_done;
        p = ext_val(m, sgn, 1'b1) * ext_val(n, sgn, 1'b0);
        uneg = u_mem[m-1][15]; vneg = v_mem[n-1][15];
        lat = m + n * (m + 1) + ((sgn && uneg) ? n : 0) + ((sgn && vneg) ? m : 0);
        fv = 16'($urandom);
        @(negedge clk); fill_req = 1'b1; fill_val = fv;
        @(negedge clk); fill_req = 1'b0;
        start = 1'b1; signed_mode = sgn; m_cnt = 3'(m); n_cnt = 3'(n);
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        cnt = 0; saw_done = 1'b0;
        while (cnt < 4000) begin
            @(posedge clk); cnt++;
            @(negedge clk);
            if (done) begin saw_done = 1'b1; break; end
            if (inject && cnt == 2) begin
                start = 1'b1; signed_mode = !sgn; m_cnt = 3'd1; n_cnt = 3'd1;
            end else begin
                start = 1'b0;
            end
        end
        start = 1'b0; m_cnt = 3'(m); n_cnt = 3'(n);
        // R2: latency from accepted start to done
        check(saw_done && cnt == lat, {"R2 latency ", tag}, 64'(cnt), 64'(lat));
        @(negedge clk);
        // R2: one-cycle pulse
        check(!done, {"R2 pulse ", tag}, 64'(done), 64'd0);
        ok_res = 1'b1; bad_at = 0; got = '0; want = '0;
        for (int k = 0; k < m + n; k++) begin
            if (ok_res && w_mem[k] !== p[16*k +: 16]) begin
                ok_res = 1'b0; bad_at = k; got = w_mem[k]; want = p[16*k +: 16];
            end
        end
        check(ok_res, {tag, " product"}, {16'(bad_at), 32'h0, got}, {16'(bad_at), 32'h0, want});
        ok_fill = 1'b1; got = '0; want = '0;
        for (int k = m + n; k < WD; k++) begin
            if (ok_fill && w_mem[k] !== (fv ^ 16'(k * 16'h1357))) begin
                ok_fill = 1'b0; got = w_mem[k]; want = fv ^ 16'(k * 16'h1357);
            end
        end
        // R9: nothing written above m+n
        check(ok_fill, {"R9 untouched ", tag}, 64'(got), 64'(want));
    endtask

    task automatic load(input int m, input int n, input logic [15:0] uf, input logic [15:0] vf, input bit rnd);
        for (int k = 0; k < MM; k++) u_mem[k] = rnd ? 16'($urandom) : uf;
        for (int k = 0; k < NN; k++) v_mem[k] = rnd ? 16'($urandom) : vf;
        if (m > 0 && n > 0) ;
    endtask

    initial begin
        int seed_val;
        seed_val = $urandom(32'd20240611);
        for (int k = 0; k < MM; k++) u_mem[k] = '0;
        for (int k = 0; k < NN; k++) v_mem[k] = '0;
        for (int k = 0; k < WD; k++) w_mem[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state
        check(!done && !w_we, "R9 reset quiet", {62'd0, done, w_we}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !w_we, "R2 idle no done", {62'd0, done, w_we}, 64'd0);

        load(1, 1, 16'hFFFF, 16'hFFFF, 1'b0);
        run_op(1, 1, 1'b0, 1'b0, "R1 1x1 max");
        load(MM, NN, 16'hFFFF, 16'hFFFF, 1'b0);
        run_op(MM, NN, 1'b0, 1'b0, "R4 all ones");
        run_op(MM, NN, 1'b0, 1'b0, "R7 unsigned top set");
        load(3, 2, 16'h1234, 16'h0000, 1'b1);
        run_op(3, 2, 1'b0, 1'b0, "R3 garbage w");
        load(MM, NN, 16'hFFFF, 16'hFFFF, 1'b0);
        run_op(MM, NN, 1'b1, 1'b0, "R6 minus one squared R10");
        load(4, 3, 16'h0, 16'h0, 1'b1);
        u_mem[3] = 16'h8000; v_mem[2] = 16'h8000;
        for (int k = 0; k < 3; k++) u_mem[k] = 16'h0;
        for (int k = 0; k < 2; k++) v_mem[k] = 16'h0;
        run_op(4, 3, 1'b1, 1'b0, "R6 most negative");
        load(5, 2, 16'h0, 16'h0, 1'b1);
        u_mem[4][15] = 1'b1; v_mem[1][15] = 1'b0;
        run_op(5, 2, 1'b1, 1'b0, "R5 u negative");
        load(2, 5, 16'h0, 16'h0, 1'b1);
        u_mem[1][15] = 1'b0; v_mem[4][15] = 1'b1;
        run_op(2, 5, 1'b1, 1'b0, "R5 v negative");
        load(4, 4, 16'h0, 16'h0, 1'b1);
        u_mem[3][15] = 1'b1; v_mem[3][15] = 1'b1;
        run_op(4, 4, 1'b1, 1'b1, "R8 start while busy");
        load(3, 4, 16'h0, 16'h0, 1'b1);
        run_op(3, 4, 1'b0, 1'b1, "R8 start while busy unsigned");

        for (int r = 0; r < 30; r++) begin
            int m, n;
            bit sg;
            m = 1 + int'($urandom % MM);
            n = 1 + int'($urandom % NN);
            sg = 1'($urandom);
            load(m, n, 16'h0, 16'h0, 1'b1);
            if (($urandom % 3) == 0) u_mem[m-1][15] = 1'b1;
            if (($urandom % 3) == 0) v_mem[n-1][15] = 1'b1;
            run_op(m, n, sg, 1'b0, sg ? "R5 random signed" : "R1 random unsigned");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule